// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a small set of recent virtual-page to physical-page mappings in front of a page table walker. A lookup presents a virtual page number and whether the access is a store. In the same cycle the block answers with a hit, the physical page number and the entry's permission flags. Otherwise it raises a walk request. The walker then resolves the mapping, loads it through the fill port and the access is retried.

Every entry can hold any page, so a lookup compares against all entries at once. The block never writes to the page table. Whoever owns the tables keeps the block coherent. A pulse on the base-change input drops every mapping, for example on a context switch. An invalidate with a virtual page number drops one mapping after a table entry has been edited. A store that would need the dirty flag set in memory is sent to the walker as a miss. The walker then refreshes the entry with a fill.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a fill has been accepted.
- R2: A lookup answers combinationally in the cycle it is presented. `lk_hit` and `walk_req` are never high together, and both stay low while `lk_valid` is low. On a hit, `lk_ppn` carries the stored physical page number.
- R3: A cycle with `base_change` high makes every entry invalid from the next cycle on.
- R4: A cycle with `inv_valid` high makes only the entry whose tag equals `inv_vpn` invalid from the next cycle on. All other entries keep their mappings.
- R5: A store lookup (`lk_store` high) that matches an entry whose dirty flag (bit 0 of the permission field) is clear is reported as a miss, with `walk_req` high.
- R6: A fill accepted at a clock edge is visible to lookups from the next cycle on. A fill for a page that is already held overwrites that same entry, so the refreshed flags replace the old ones without creating a duplicate.
- R7: A fill in the same cycle as `base_change` is dropped. A fill in the same cycle as an invalidate of the same page is dropped. A fill beside an invalidate of a different page is kept.
- R8: A fill of a new page goes into the lowest-numbered invalid entry while any entry is invalid. No valid mapping is evicted in that case.
- R9: With all entries valid, a fill replaces the entry chosen by a binary tree pseudo-LRU. Each tree node points away from the half touched most recently, where a hit or a fill counts as a touch. After fills of pages into entries 0 to 15 in order and a hit on entry 0, the next new page replaces entry 8.
- R10: The permission field is ordered read, write, execute, dirty from bit 3 down to bit 0. It is returned on a hit exactly as it was filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_store | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation found and usable |
| lk_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| lk_perm | output | 4 | Read, write, execute, dirty flags on a hit |
| walk_req | output | 1 | Lookup missed; the walker must resolve it |
| fill_valid | input | 1 | Load a mapping from the walker |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_ppn | input | PPN_W | Physical page of the fill |
| fill_perm | input | 4 | Flags of the fill, same order as lk_perm |
| base_change | input | 1 | Table base changed: drop every entry |
| inv_valid | input | 1 | Drop the entry for one page |
| inv_vpn | input | VPN_W | Page to drop |

## Verification
The hardest state to reach from the ports is a known replacement choice with the buffer full. The tree bits cannot be read, and they depend on every earlier hit and fill. The stimulus flushes the buffer and fills sixteen pages in order, which touches every tree node and so sets all of them to known values whatever came before. One hit on the first page then follows. The next new page must evict entry 8, and lookups of the neighbouring pages show which one left. An invalidate followed by a fill then shows that an invalid slot is taken ahead of the tree's choice.

// File: rtl/page_xlate_cache.sv
module page_xlate_cache #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [3:0]       lk_perm,
  output logic             walk_req,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_perm,
  input  logic             base_change,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int NODES = ENTRIES - 1;

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [3:0]         perm_q [ENTRIES];
  logic [NODES-1:0]   tree;

  logic [ENTRIES-1:0] lk_m, fl_m, iv_m;
  logic [IDX_W-1:0]   lk_idx, fl_idx, free_idx, plru_idx, fill_idx;

  always_comb begin
    lk_idx   = '0;
    fl_idx   = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_m[i] = vld[i] && (tag_q[i] == lk_vpn);
      fl_m[i] = vld[i] && (tag_q[i] == fill_vpn);
      iv_m[i] = vld[i] && (tag_q[i] == inv_vpn);
      if (lk_m[i]) lk_idx = IDX_W'(i);
      if (fl_m[i]) fl_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    int n;
    n = 0;
    for (int l = 0; l < IDX_W; l++) n = 2 * n + 1 + int'(tree[n]);
    plru_idx = IDX_W'(n - NODES);
  end

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [IDX_W-1:0] e);
    int n, p;
    n = int'(e) + NODES;
    for (int l = 0; l < IDX_W; l++) begin
      p    = (n - 1) / 2;
      t[p] = (n % 2 == 1);
      n    = p;
    end
    return t;
  endfunction

  logic hit_raw, fill_go;
  assign hit_raw  = lk_valid && (|lk_m);
  assign lk_hit   = hit_raw && !(lk_store && !perm_q[lk_idx][0]);
  assign walk_req = lk_valid && !lk_hit;
  assign lk_ppn   = lk_hit ? ppn_q[lk_idx]  : '0;
  assign lk_perm  = lk_hit ? perm_q[lk_idx] : '0;

  assign fill_go  = fill_valid && !base_change && !(inv_valid && inv_vpn == fill_vpn);
  assign fill_idx = (|fl_m) ? fl_idx : (~&vld ? free_idx : plru_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      tree <= '0;
    end else begin
      logic [ENTRIES-1:0] v;
      logic [NODES-1:0]   t;
      v = inv_valid ? (vld & ~iv_m) : vld;
      if (fill_go) v[fill_idx] = 1'b1;
      vld <= base_change ? '0 : v;
      t = tree;
      if (lk_hit)  t = touch(t, lk_idx);
      if (fill_go) t = touch(t, fill_idx);
      tree <= t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fill_go) begin
      tag_q[fill_idx]  <= fill_vpn;
      ppn_q[fill_idx]  <= fill_ppn;
      perm_q[fill_idx] <= fill_perm;
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_store,
  input logic             lk_hit,
  input logic [PPN_W-1:0] lk_ppn,
  input logic [3:0]       lk_perm,
  input logic             walk_req,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             base_change,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn
);
  p_hit_walk_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && walk_req));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !walk_req));

  p_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_change |=> !lk_hit);

  p_inv_gone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_hit && lk_vpn == $past(inv_vpn)));

  p_store_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_store) |-> lk_perm[0]);

  p_fill_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !base_change && !(inv_valid && inv_vpn == fill_vpn)) |=>
      (!(lk_valid && !lk_store && lk_vpn == $past(fill_vpn)) ||
       (lk_hit && lk_ppn == $past(fill_ppn))));
endmodule

bind page_xlate_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .lk_store(lk_store), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
  .walk_req(walk_req), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
  .fill_ppn(fill_ppn), .base_change(base_change), .inv_valid(inv_valid),
  .inv_vpn(inv_vpn));

// File: tb/tb_page_xlate_cache.sv
module tb_page_xlate_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_store = 1'b0, fill_valid = 1'b0;
  logic base_change = 1'b0, inv_valid = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0, inv_vpn = '0;
  logic [3:0]  fill_perm = '0;
  logic        lk_hit, walk_req;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_perm;

  always #4 clk = ~clk;

  page_xlate_cache dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_store(lk_store), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .walk_req(walk_req), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .base_change(base_change),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_store = 0; fill_valid = 0; base_change = 0; inv_valid = 0;
  endtask

  task automatic look(input logic [19:0] v, input logic st, input logic eh,
                      input logic [19:0] ep, input string req);
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = v; lk_store = st;
    #2;
    chk(lk_hit == eh, req, 32'(lk_hit), 32'(eh));
    chk(walk_req == !eh, req, 32'(walk_req), 32'(!eh));
    if (eh) chk(lk_ppn == ep, req, 32'(lk_ppn), 32'(ep));
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pm);
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = v; fill_ppn = p; fill_perm = pm;
  endtask

  task automatic inval(input logic [19:0] v);
    @(negedge clk); idle(); inv_valid = 1; inv_vpn = v;
  endtask

  task automatic flush();
    @(negedge clk); idle(); base_change = 1;
  endtask

  // op: 0 lookup, 1 fill, 2 invalidate, 3 flush; perm {r,w,x,d}
  typedef struct packed {
    logic [1:0]  op;
    logic        st;
    logic [19:0] vpn;
    logic [19:0] ppn;
    logic [3:0]  perm;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd0, 1'b0, 20'h00010, 20'h00000, 4'h0, 1'b0, 4'd1},  // R1 empty
    '{2'd1, 1'b0, 20'h00010, 20'h0A010, 4'hC, 1'b0, 4'd6},
    '{2'd0, 1'b0, 20'h00010, 20'h0A010, 4'h0, 1'b1, 4'd2},  // R2 hit
    '{2'd0, 1'b1, 20'h00010, 20'h00000, 4'h0, 1'b0, 4'd5},  // R5 clean store
    '{2'd1, 1'b0, 20'h00010, 20'h0A010, 4'hD, 1'b0, 4'd6},
    '{2'd0, 1'b1, 20'h00010, 20'h0A010, 4'h0, 1'b1, 4'd6},  // R6 refresh
    '{2'd1, 1'b0, 20'h00020, 20'h0B020, 4'hA, 1'b0, 4'd6},
    '{2'd0, 1'b0, 20'h00020, 20'h0B020, 4'h0, 1'b1, 4'd6},
    '{2'd2, 1'b0, 20'h00010, 20'h00000, 4'h0, 1'b0, 4'd4},
    '{2'd0, 1'b0, 20'h00010, 20'h00000, 4'h0, 1'b0, 4'd4},  // R4 dropped
    '{2'd0, 1'b0, 20'h00020, 20'h0B020, 4'h0, 1'b1, 4'd4},  // R4 kept
    '{2'd3, 1'b0, 20'h00000, 20'h00000, 4'h0, 1'b0, 4'd3},
    '{2'd0, 1'b0, 20'h00020, 20'h00000, 4'h0, 1'b0, 4'd3}   // R3 flushed
  };

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk); lk_valid = 1; lk_vpn = 20'h00010; #2;
    chk(!lk_hit && walk_req, "R1 in reset", 32'(lk_hit), 32'(0));
    @(negedge clk); idle(); rst_n = 1;

    foreach (VECS[k]) begin
      case (VECS[k].op)
        2'd0: look(VECS[k].vpn, VECS[k].st, VECS[k].hit, VECS[k].ppn,
                   $sformatf("R%0d vec %0d", VECS[k].req, k));
        2'd1: fill(VECS[k].vpn, VECS[k].ppn, VECS[k].perm);
        2'd2: inval(VECS[k].vpn);
        default: flush();
      endcase
    end

    // R9: fill entries 0..15 in order, touch entry 0, next victim is entry 8
    flush();
    for (int i = 0; i < 16; i++) fill(20'h100 + 20'(i), 20'h5000 + 20'(i), 4'h8);
    look(20'h100, 0, 1, 20'h5000, "R9 touch entry 0");
    fill(20'h200, 20'h6200, 4'h8);
    look(20'h108, 0, 0, 20'h0, "R9 entry 8 evicted");
    look(20'h200, 0, 1, 20'h6200, "R9 new page");
    look(20'h10F, 0, 1, 20'h500F, "R9 neighbour kept");

    // R8: a freed slot is used before any valid entry is evicted
    inval(20'h105);
    fill(20'h300, 20'h6300, 4'h8);
    look(20'h300, 0, 1, 20'h6300, "R8 free slot");
    for (int i = 0; i < 16; i++)
      if (i != 5 && i != 8)
        look(20'h100 + 20'(i), 0, 1, 20'h5000 + 20'(i), "R8 no eviction");

    // R10 permission order, R5 store on clean page
    flush();
    fill(20'h777, 20'h1777, 4'b0110);
    @(negedge clk); idle(); lk_valid = 1; lk_vpn = 20'h777; #2;
    chk(lk_hit && lk_perm == 4'b0110, "R10 perm order", 32'(lk_perm), 32'(4'b0110));
    look(20'h777, 1, 0, 20'h0, "R5 store clean");

    // R7 priorities
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = 20'h400; fill_ppn = 20'h1400; fill_perm = 4'hF;
    base_change = 1;
    look(20'h400, 0, 0, 20'h0, "R7 flush beats fill");
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = 20'h500; fill_ppn = 20'h1500; fill_perm = 4'hF;
    inv_valid = 1; inv_vpn = 20'h500;
    look(20'h500, 0, 0, 20'h0, "R7 inv same page");
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = 20'h700; fill_ppn = 20'h1700; fill_perm = 4'hF;
    inv_valid = 1; inv_vpn = 20'h600;
    look(20'h700, 0, 1, 20'h1700, "R7 inv other page");

    @(negedge clk); idle(); #2;
    chk(!lk_hit && !walk_req, "R2 idle", 32'(walk_req), 32'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule